// File: doc/BRIEF.md
# Register-Level Serial Configuration Port

This block is a synchronous serial slave that lets a host read and write a bank of configuration registers of mixed widths. Every transaction opens with an instruction byte shifted in on eight rising serial-clock edges. That byte carries a direction flag and a register address. A data phase follows, and its length in bytes is taken from the width of the addressed register. Transfers always cover whole registers. A write reaches the register file only once its final bit has arrived.

The port samples its serial input on rising edges of the serial clock and updates its serial output on falling edges. Two mode inputs select the bit order (most or least significant bit first, for both instruction and data) and the pin arrangement. In the 2-wire arrangement one bidirectional data pin is used, and the block raises an enable when it drives it. In the 3-wire arrangement a separate output pin carries read data. An active-low chip select frames transactions. A sync/abort input drops a partial transfer and re-arms the port to expect an instruction byte.

The serial clock, chip select, abort and data inputs are sampled in the `clk` domain, so they must be synchronous to it and slower than it. The sequencer has three states. `PH_IDLE` is entered whenever chip select is high. `PH_IDLE` moves to `PH_INSTR` on the first `clk` with chip select low. `PH_INSTR` moves to `PH_DATA` on the eighth rising serial-clock edge. `PH_DATA` moves back to `PH_INSTR` on the rising edge that carries the last data bit. Any state moves to `PH_INSTR` while abort is high and chip select is low.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset all register words read as zero, `sdo` is 0 and both output enables are low while `cs_n` is high.
- R2: The instruction byte is taken from the first eight rising `sclk` edges with `cs_n` low. Its bit 7 is 1 for a read and 0 for a write. Bits 4:0 give the address, and bits 6 and 5 have no effect.
- R3: The data phase lasts exactly (address mod 4)+1 bytes for mapped addresses 0 to NUM_REGS-1, so with the default there are two each of 8, 16, 24 and 32-bit registers.
- R4: A write changes the register file only on the rising edge that carries the last data bit. The new value is visible on `regs_o` one `clk` later and is limited to the register's width.
- R5: During a read data phase each falling `sclk` edge presents the next register bit. The bit is held until the next falling edge, so the host can sample it on the rising edge.
- R6: With `cfg_lsb_first` = 0, the instruction bit 7 goes first and the data starts at the register's top bit. With `cfg_lsb_first` = 1 both start at bit 0. The stored value does not depend on the order used to write it.
- R7: With `cfg_sdo_sep` = 1, `sdo_oe` equals not `cs_n`, read data appears on `sdo` and `sdio_oe` stays low. With `cfg_sdo_sep` = 0, `sdio_oe` is high only during a read data phase with `cs_n` low, read data appears on `sdio_out`, and `sdo_oe` stays low.
- R8: `sync_abort` high with `cs_n` low drops the current transfer without committing it. This holds even in the same `clk` as the final rising edge. The next eight rising edges form a new instruction.
- R9: `cs_n` high drops any partial transfer without commit, clears the read output, and makes the next low period start with an instruction byte.
- R10: An address of NUM_REGS or above has a one-byte data phase. A read of it returns zeros and a write of it changes no register.
- R11: Once a data phase completes, the following eight rising edges are a new instruction even if `cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sync_abort | input | 1 | Aborts the current transfer and re-arms for an instruction |
| cfg_lsb_first | input | 1 | 1 selects least-significant-bit-first order |
| cfg_sdo_sep | input | 1 | 1 selects separate output pin (3-wire), 0 shared pin (2-wire) |
| sdio_in | input | 1 | Serial data input (input side of the shared pin) |
| sdio_out | output | 1 | Read data for the shared pin |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| sdo | output | 1 | Read data on the separate output pin |
| sdo_oe | output | 1 | Drive enable for the separate output pin |
| regs_o | output | NUM_REGS*32 | Register words, word i at bits 32*i+31 : 32*i |

## Verification
An abort and the rising edge that carries a write's last data bit can land in the same `clk`. In that case the completion would commit the register and the abort would discard the transfer. The bench raises `sclk` for the final bit and `sync_abort` at the same time. It expects the register word to keep its old value, and it expects a read that follows with chip select still low to return that old value. The cycle-by-cycle reference model judges `regs_o` and the serial outputs on every clock during that overlap.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int INSTR_BITS = 8;
    localparam int ADDR_BITS  = 5;
    localparam int RD_FLAG    = 7;
    localparam int MAX_BYTES  = 4;
    localparam int WORD_BITS  = MAX_BYTES * 8;
    localparam int CNT_W      = $clog2(WORD_BITS + 1);
    localparam int POS_W      = $clog2(WORD_BITS);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INSTR = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;

    // Bytes moved in the data phase for a given address; unmapped -> 1.
    function automatic int unsigned reg_bytes(input logic [ADDR_BITS-1:0] a,
                                              input int unsigned nregs);
        if (32'(a) < nregs) return (32'(a) % MAX_BYTES) + 1;
        return 1;
    endfunction

endpackage

// File: rtl/sio_edge_detect.sv
module sio_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;
    assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/sio_seq.sv
module sio_seq import sio_pkg::*; #(
    parameter int NUM_REGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 abort_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 lsb_first_i,
    input  logic                 sdi_i,
    output phase_e               phase_o,
    output logic                 rd_o,
    output logic [ADDR_BITS-1:0] addr_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [CNT_W-1:0]     nbits_o,
    output logic [POS_W-1:0]     pos_o,
    output logic                 wr_bit_o,
    output logic                 commit_o,
    output logic                 clear_o,
    output logic                 load_o
);
    phase_e                 phase_q, phase_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [INSTR_BITS-1:0]  instr_q, instr_d, instr_next;
    logic                   rd_q, rd_d;
    logic [ADDR_BITS-1:0]   addr_q, addr_d;
    logic [2:0]             ipos;
    logic                   live, last_instr, last_data;

    assign live    = ~cs_n & ~abort_i;
    assign nbits_o = CNT_W'(reg_bytes(addr_q, NUM_REGS) * 8);
    assign ipos    = lsb_first_i ? cnt_q[2:0] : 3'(7 - int'(cnt_q[2:0]));
    assign pos_o   = lsb_first_i ? POS_W'(cnt_q)
                                 : POS_W'(nbits_o - CNT_W'(1) - cnt_q);

    always_comb begin
        instr_next       = instr_q;
        instr_next[ipos] = sdi_i;
    end

    assign last_instr = (cnt_q == CNT_W'(INSTR_BITS - 1));
    assign last_data  = (cnt_q == nbits_o - CNT_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            instr_q <= '0;
            rd_q    <= 1'b0;
            addr_q  <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            instr_q <= instr_d;
            rd_q    <= rd_d;
            addr_q  <= addr_d;
        end
    end

    // Next state
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        instr_d = instr_q;
        rd_d    = rd_q;
        addr_d  = addr_q;
        if (cs_n) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else if (abort_i) begin
            phase_d = PH_INSTR;
            cnt_d   = '0;
        end else begin
            unique case (phase_q)
                PH_IDLE, PH_INSTR: begin
                    phase_d = PH_INSTR;
                    if (rise_i) begin
                        instr_d = instr_next;
                        if (last_instr) begin
                            phase_d = PH_DATA;
                            cnt_d   = '0;
                            rd_d    = instr_next[RD_FLAG];
                            addr_d  = instr_next[ADDR_BITS-1:0];
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                PH_DATA: begin
                    if (rise_i) begin
                        if (last_data) begin
                            phase_d = PH_INSTR;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_bit_o = live & (phase_q == PH_DATA) & rise_i & ~rd_q;
        commit_o = wr_bit_o & last_data;
        clear_o  = ~live | ((phase_q == PH_DATA) & rise_i & last_data);
        load_o   = live & (phase_q == PH_DATA) & rd_q & fall_i;
    end

    assign phase_o = phase_q;
    assign rd_o    = rd_q;
    assign addr_o  = addr_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank import sio_pkg::*; #(
    parameter int NUM_REGS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_bit_i,
    input  logic                          commit_i,
    input  logic                          sdi_i,
    input  logic [POS_W-1:0]              pos_i,
    input  logic [CNT_W-1:0]              nbits_i,
    input  logic [ADDR_BITS-1:0]          addr_i,
    output logic [WORD_BITS-1:0]          rd_word_o,
    output logic [NUM_REGS*WORD_BITS-1:0] regs_o
);
    logic [WORD_BITS-1:0] regs_q [NUM_REGS];
    logic [WORD_BITS-1:0] buf_q, buf_next, mask;
    logic [WORD_BITS:0]   mask_ext;

    always_comb begin
        buf_next         = buf_q;
        buf_next[pos_i]  = sdi_i;
    end

    assign mask_ext = ({{WORD_BITS{1'b0}}, 1'b1} << nbits_i) - 1'b1;
    assign mask     = mask_ext[WORD_BITS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else if (wr_bit_i) buf_q <= buf_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (commit_i) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (addr_i == ADDR_BITS'(i)) regs_q[i] <= buf_next & mask;
        end
    end

    always_comb begin
        rd_word_o = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr_i == ADDR_BITS'(i)) rd_word_o = regs_q[i];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*WORD_BITS +: WORD_BITS] = regs_q[g];
    end
endmodule

// File: rtl/sio_txout.sv
module sio_txout import sio_pkg::*; (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 load_i,
    input  logic [WORD_BITS-1:0] word_i,
    input  logic [POS_W-1:0]     pos_i,
    output logic                 bit_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bit_o <= 1'b0;
        else if (clear_i) bit_o <= 1'b0;
        else if (load_i)  bit_o <= word_i[pos_i];
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port import sio_pkg::*; #(
    parameter int NUM_REGS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk,
    input  logic                          cs_n,
    input  logic                          sync_abort,
    input  logic                          cfg_lsb_first,
    input  logic                          cfg_sdo_sep,
    input  logic                          sdio_in,
    output logic                          sdio_out,
    output logic                          sdio_oe,
    output logic                          sdo,
    output logic                          sdo_oe,
    output logic [NUM_REGS*WORD_BITS-1:0] regs_o
);
    logic                 rise, fall;
    phase_e               phase;
    logic                 is_rd;
    logic [ADDR_BITS-1:0] addr;
    logic [CNT_W-1:0]     cnt, nbits;
    logic [POS_W-1:0]     pos;
    logic                 wr_bit, commit, clear, load;
    logic [WORD_BITS-1:0] rd_word;
    logic                 out_bit;

    sio_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .rise_o (rise),
        .fall_o (fall)
    );

    sio_seq #(.NUM_REGS(NUM_REGS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .abort_i     (sync_abort),
        .rise_i      (rise),
        .fall_i      (fall),
        .lsb_first_i (cfg_lsb_first),
        .sdi_i       (sdio_in),
        .phase_o     (phase),
        .rd_o        (is_rd),
        .addr_o      (addr),
        .cnt_o       (cnt),
        .nbits_o     (nbits),
        .pos_o       (pos),
        .wr_bit_o    (wr_bit),
        .commit_o    (commit),
        .clear_o     (clear),
        .load_o      (load)
    );

    sio_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_bit_i  (wr_bit),
        .commit_i  (commit),
        .sdi_i     (sdio_in),
        .pos_i     (pos),
        .nbits_i   (nbits),
        .addr_i    (addr),
        .rd_word_o (rd_word),
        .regs_o    (regs_o)
    );

    sio_txout u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .load_i  (load),
        .word_i  (rd_word),
        .pos_i   (pos),
        .bit_o   (out_bit)
    );

    assign sdio_out = out_bit;
    assign sdo      = cfg_sdo_sep & out_bit;
    assign sdo_oe   = cfg_sdo_sep & ~cs_n;
    assign sdio_oe  = ~cfg_sdo_sep & ~cs_n & (phase == PH_DATA) & is_rd;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk import sio_pkg::*; #(
    parameter int NUM_REGS = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cs_n,
    input logic                          sync_abort,
    input logic                          rise,
    input logic                          fall,
    input phase_e                        phase,
    input logic                          is_rd,
    input logic [CNT_W-1:0]              cnt,
    input logic [CNT_W-1:0]              nbits,
    input logic                          out_bit,
    input logic                          sdo_oe,
    input logic                          sdio_oe,
    input logic [NUM_REGS*WORD_BITS-1:0] regs_o
);
    a_r9_cs_high_idles: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == PH_IDLE) && (cnt == '0));

    a_r8_abort_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sync_abort) |=> (phase == PH_INSTR) && (cnt == '0));

    a_r4_commit_at_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(!cs_n && !sync_abort && phase == PH_DATA
                                   && !is_rd && rise && cnt == nbits - CNT_W'(1)));

    a_r5_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_bit) |-> $past(fall || rise || cs_n || sync_abort));

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (cnt < nbits));

    a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdo_oe && sdio_oe));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sync_abort (sync_abort),
    .rise       (rise),
    .fall       (fall),
    .phase      (phase),
    .is_rd      (is_rd),
    .cnt        (cnt),
    .nbits      (nbits),
    .out_bit    (out_bit),
    .sdo_oe     (sdo_oe),
    .sdio_oe    (sdio_oe),
    .regs_o     (regs_o)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, sync_abort = 1'b0;
    logic cfg_lsb_first = 1'b0, cfg_sdo_sep = 1'b1, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo, sdo_oe;
    logic [NR*32-1:0] regs_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sio_cfg_port #(.NUM_REGS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .sync_abort(sync_abort), .cfg_lsb_first(cfg_lsb_first),
        .cfg_sdo_sep(cfg_sdo_sep), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
        .sdo_oe(sdo_oe), .regs_o(regs_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int mbytes(input int a);
        return (a < NR) ? (a % 4) + 1 : 1;
    endfunction

    function automatic logic [31:0] word(input int i);
        return regs_o[i*32 +: 32];
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_st = 0;          // 0 idle, 1 instruction, 2 data
    int          m_cnt = 0;
    int          m_addr = 0;
    int          m_nb, m_pos;
    logic        m_rd = 1'b0, m_out = 1'b0, m_sq = 1'b0, m_r, m_f;
    logic [7:0]  m_instr = '0;
    logic [31:0] m_buf = '0, m_mask;
    logic [31:0] m_regs [NR];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_out = 1'b0; m_sq = 1'b0; m_rd = 1'b0;
            for (int i = 0; i < NR; i++) m_regs[i] = '0;
        end else begin
            m_r = sclk & ~m_sq;
            m_f = ~sclk & m_sq;
            if (cs_n) begin
                m_st = 0; m_cnt = 0; m_out = 1'b0;
            end else if (sync_abort) begin
                m_st = 1; m_cnt = 0; m_out = 1'b0;
            end else begin
                if (m_st == 0) m_st = 1;
                m_nb = mbytes(m_addr) * 8;
                if (m_r && m_st == 1) begin
                    m_instr[cfg_lsb_first ? m_cnt : 7 - m_cnt] = sdio_in;
                    m_cnt++;
                    if (m_cnt == 8) begin
                        m_rd = m_instr[7]; m_addr = int'(m_instr[4:0]);
                        m_st = 2; m_cnt = 0;
                    end
                end else if (m_r && m_st == 2) begin
                    m_pos = cfg_lsb_first ? m_cnt : m_nb - 1 - m_cnt;
                    if (!m_rd) m_buf[m_pos] = sdio_in;
                    m_cnt++;
                    if (m_cnt == m_nb) begin
                        m_mask = (m_nb == 32) ? 32'hFFFF_FFFF : (32'd1 << m_nb) - 1;
                        if (!m_rd && m_addr < NR) m_regs[m_addr] = m_buf & m_mask;
                        m_st = 1; m_cnt = 0; m_out = 1'b0;
                    end
                end else if (m_f && m_st == 2 && m_rd) begin
                    m_pos = cfg_lsb_first ? m_cnt : m_nb - 1 - m_cnt;
                    m_out = (m_addr < NR) ? m_regs[m_addr][m_pos] : 1'b0;
                end
            end
            m_sq = sclk;
        end
        #2;
        if (rst_n) begin
            chk("R5", "sdio_out vs model", {31'd0, sdio_out}, {31'd0, m_out});
            chk("R7", "sdo vs model", {31'd0, sdo}, {31'd0, cfg_sdo_sep & m_out});
            chk("R7", "sdo_oe vs model", {31'd0, sdo_oe}, {31'd0, cfg_sdo_sep & ~cs_n});
            chk("R7", "sdio_oe vs model", {31'd0, sdio_oe},
                {31'd0, ~cfg_sdo_sep & ~cs_n & (m_st == 2) & m_rd});
            for (int i = 0; i < NR; i++)
                chk("R4", $sformatf("reg%0d vs model", i), word(i), m_regs[i]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic xfer(input logic rd, input logic [7:0] ib, input int nbits,
                        input logic [31:0] wd, input int nshift,
                        input logic abort_last, output logic [31:0] rdv);
        logic b, got;
        int   pos;
        rdv = '0;
        for (int i = 0; i < nshift; i++) begin
            if (i < 8) begin
                pos = cfg_lsb_first ? i : 7 - i;
                b   = ib[pos];
            end else begin
                pos = cfg_lsb_first ? i - 8 : nbits - 1 - (i - 8);
                b   = rd ? 1'b0 : wd[pos];
            end
            @(negedge clk);
            sclk = 1'b0; sdio_in = b;
            repeat (3) @(negedge clk);
            got = cfg_sdo_sep ? sdo : sdio_out;
            if (i >= 8 && rd) rdv[pos] = got;
            sclk = 1'b1;
            if (abort_last && i == nshift - 1) sync_abort = 1'b1;
            @(negedge clk);
            sync_abort = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] ib, input logic [31:0] d);
        logic [31:0] dummy;
        xfer(1'b0, ib, mbytes(a) * 8, d, 8 + mbytes(a) * 8, 1'b0, dummy);
        repeat (2) @(negedge clk);
    endtask

    task automatic rdreg(input int a, input logic [7:0] ib, output logic [31:0] v);
        xfer(1'b1, ib, mbytes(a) * 8, '0, 8 + mbytes(a) * 8, 1'b0, v);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_abort();
        @(negedge clk); sync_abort = 1'b1;
        repeat (2) @(negedge clk); sync_abort = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_mode(input logic lsb, input logic sep);
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        cfg_lsb_first = lsb; cfg_sdo_sep = sep;
        repeat (2) @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // ---------------- directed sequence ----------------
    logic [31:0]   rv;
    logic [NR*32-1:0] snap;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        for (int i = 0; i < NR; i++) chk("R1", "reset word", word(i), 32'd0);
        chk("R1", "sdo_oe idle", {31'd0, sdo_oe}, 32'd0);
        chk("R1", "sdio_oe idle", {31'd0, sdio_oe}, 32'd0);
        chk("R1", "sdo idle", {31'd0, sdo}, 32'd0);

        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        // R3/R4: 32-bit register, MSB first, 3-wire
        wr(3, 8'h03, 32'hDEAD_BEEF);
        chk("R4", "reg3 after write", word(3), 32'hDEAD_BEEF);
        chk("R7", "sdo_oe with cs low", {31'd0, sdo_oe}, 32'd1);
        rdreg(3, 8'h83, rv);
        chk("R5", "reg3 read on sdo", rv, 32'hDEAD_BEEF);
        // R3: 24-bit register, then back-to-back read (R11)
        wr(2, 8'h02, 32'h0012_3456);
        chk("R3", "reg2 24-bit write", word(2), 32'h0012_3456);
        rdreg(2, 8'h82, rv);
        chk("R11", "reg2 read back to back", rv, 32'h0012_3456);
        // R2: bits 6 and 5 ignored
        wr(0, 8'h60, 32'h0000_00A7);
        chk("R2", "reg0 via 0x60", word(0), 32'h0000_00A7);
        rdreg(0, 8'hE0, rv);
        chk("R2", "reg0 read via 0xE0", rv, 32'h0000_00A7);

        // R6: LSB-first
        set_mode(1'b1, 1'b1);
        wr(1, 8'h01, 32'h0000_A55C);
        chk("R6", "reg1 lsb-first write", word(1), 32'h0000_A55C);
        rdreg(1, 8'h81, rv);
        chk("R6", "reg1 lsb-first read", rv, 32'h0000_A55C);
        set_mode(1'b0, 1'b1);
        rdreg(1, 8'h81, rv);
        chk("R6", "reg1 msb-first read", rv, 32'h0000_A55C);

        // R7: 2-wire read
        set_mode(1'b0, 1'b0);
        rdreg(3, 8'h83, rv);
        chk("R7", "reg3 read on sdio_out", rv, 32'hDEAD_BEEF);
        xfer(1'b1, 8'h83, 32, '0, 20, 1'b0, rv);
        chk("R7", "sdio_oe mid read", {31'd0, sdio_oe}, 32'd1);
        chk("R7", "sdo_oe in 2-wire", {31'd0, sdo_oe}, 32'd0);
        pulse_abort();
        chk("R8", "sdio_oe after abort", {31'd0, sdio_oe}, 32'd0);
        set_mode(1'b0, 1'b1);

        // R8: abort mid write
        xfer(1'b0, 8'h02, 24, 32'h00FF_FFFF, 20, 1'b0, rv);
        pulse_abort();
        chk("R8", "reg2 after aborted write", word(2), 32'h0012_3456);
        rdreg(2, 8'h82, rv);
        chk("R8", "read after abort re-arm", rv, 32'h0012_3456);
        // R8: abort coinciding with the last rising edge
        xfer(1'b0, 8'h03, 32, 32'h1111_1111, 40, 1'b1, rv);
        repeat (2) @(negedge clk);
        chk("R8", "reg3 after abort on last edge", word(3), 32'hDEAD_BEEF);
        rdreg(3, 8'h83, rv);
        chk("R8", "reg3 read after coincident abort", rv, 32'hDEAD_BEEF);

        // R9: chip select dropped mid write
        xfer(1'b0, 8'h01, 16, 32'h0000_0F0F, 15, 1'b0, rv);
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", "sdo_oe with cs high", {31'd0, sdo_oe}, 32'd0);
        chk("R9", "reg1 after cs abort", word(1), 32'h0000_A55C);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        wr(1, 8'h01, 32'h0000_0F0F);
        chk("R9", "reg1 after restart", word(1), 32'h0000_0F0F);

        // R10: unmapped address
        snap = regs_o;
        wr(20, 8'h14, 32'h0000_00FF);
        for (int i = 0; i < NR; i++)
            chk("R10", "word after unmapped write", word(i), snap[i*32 +: 32]);
        rdreg(20, 8'h94, rv);
        chk("R10", "unmapped read", rv, 32'd0);
        rdreg(0, 8'h80, rv);
        chk("R10", "read after one-byte unmapped phase", rv, 32'h0000_00A7);

        // R11: write then read in one select period
        wr(0, 8'h00, 32'h0000_003C);
        rdreg(0, 8'h80, rv);
        chk("R11", "reg0 write-then-read", rv, 32'h0000_003C);

        @(negedge clk); cs_n = 1'b1;
        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule